// File: doc/BRIEF.md
# Auto-Incrementing Indirect Register Writer

This block is a small control-register slave that offers two indirect write channels. Each channel has an address register and a data register. A write to a data register lands at the place its address register points to, and then the address moves on by one. Firmware can stream a block of values with one address write followed by a run of data writes.

The table channel fills a small on-chip lookup table, such as a dispatch jump table, which the rest of the chip reads through a plain index port. The register-space channel forwards each data write as a one-cycle request on a simple write interface. Its address register has two fields. The low half is the target offset, which advances after each write. The high half holds flags that pass through unchanged.

The slave has several write ports so that more than one control write can land in the same cycle. Both address registers can also be read back through a select-driven read port.

Top module: `irw_indirect_writer`

## Requirements
- R1: After reset both address registers read 0, `rq_valid` is 0, `tbl_err` is 0 and every bit of `reg_written` is 0.
- R2: A write with select 1 (table data) stores the value at the entry given by the table address register (select 0). The table address then increases by one.
- R3: A write with select 3 (register data) makes `rq_valid` high for exactly the next cycle. In that cycle `rq_addr` holds bits [15:0] of the register-space address (select 2) as they were before the write, and `rq_data` holds the written value.
- R4: After a register-data write, bits [15:0] of the register-space address increase by one, and bits [31:16] (the flags) keep their value.
- R5: An offset of 0xFFFF steps to 0x0000 and does not carry into the flag field.
- R6: A table-data write whose table address is at or beyond the table depth changes no table entry and sets `tbl_err`. `tbl_err` then stays set until reset. The table address still advances.
- R7: When a direct address write and a data write for the same channel land in the same cycle, the data write uses the old address. The address register then takes the directly written value, with no increment.
- R8: `cr_rd_data` shows the table address for `cr_rd_sel`=0 and the register-space address for `cr_rd_sel`=2. It shows 0 for selects 1 and 3.
- R9: A write to select s sets bit s of `reg_written`. `wr_flag_clr` clears all the bits, but a write in the same cycle as the clear still sets its own bit.
- R10: When several ports write the same register in one cycle, the port with the highest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cr_wr_en | input | N_PORTS | Write enable, one bit per port |
| cr_wr_sel | input | 2*N_PORTS | Register select per port (0 table addr, 1 table data, 2 reg addr, 3 reg data) |
| cr_wr_data | input | DATA_W*N_PORTS | Write data per port |
| cr_rd_sel | input | 2 | Read-back select |
| cr_rd_data | output | DATA_W | Read-back value |
| wr_flag_clr | input | 1 | Clears the written bits |
| reg_written | output | 4 | Per-register written bits |
| tbl_err | output | 1 | Sticky out-of-range table write error |
| tbl_rd_idx | input | $clog2(TBL_DEPTH) | Table lookup index |
| tbl_rd_data | output | DATA_W | Table entry (0 beyond the depth) |
| rq_valid | output | 1 | Register-space write request pulse |
| rq_addr | output | OFS_W | Register-space target offset |
| rq_data | output | DATA_W | Register-space write value |

## Verification
A wrong address counter shows up on the very next write. The table case appears at the lookup port and in the read-back of the table address. The register-space case appears on `rq_addr` one cycle after the data write. A flag field corrupted by a carry or by a missed hold shows up at once in the read-back of select 2, before any further request goes out. The sticky error and the written bits are outputs, so a bit that clears too early is visible in the same cycle it changes.

// File: rtl/irw_pkg.sv
package irw_pkg;
   typedef enum logic [1:0] {
      SEL_TBL_ADDR = 2'd0,
      SEL_TBL_DATA = 2'd1,
      SEL_RS_ADDR  = 2'd2,
      SEL_RS_DATA  = 2'd3
   } irw_sel_e;

   localparam int unsigned IRW_NREGS = 4;
   localparam int unsigned IRW_SELW  = 2;
endpackage

// File: rtl/irw_port_decode.sv
module irw_port_decode
   import irw_pkg::*;
#(
   parameter int unsigned N_PORTS = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic [N_PORTS-1:0]                  wr_en,
   input  logic [N_PORTS*IRW_SELW-1:0]         wr_sel,
   input  logic [N_PORTS*DATA_W-1:0]           wr_data,
   output logic [IRW_NREGS-1:0]                hit,
   output logic [IRW_NREGS-1:0][DATA_W-1:0]    hit_data
);
   // Ports are scanned in rising index order, so a later port overrides an earlier one.
   always_comb begin
      hit      = '0;
      hit_data = '0;
      for (int p = 0; p < int'(N_PORTS); p++) begin
         if (wr_en[p]) begin
            hit[wr_sel[p*IRW_SELW +: IRW_SELW]]      = 1'b1;
            hit_data[wr_sel[p*IRW_SELW +: IRW_SELW]] = wr_data[p*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/irw_table_chan.sv
module irw_table_chan #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TBL_DEPTH = 12,
   localparam int unsigned IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [DATA_W-1:0] addr_val,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] tbl_addr,
   output logic              err
);
   localparam logic [DATA_W-1:0] DEPTH_V = DATA_W'(TBL_DEPTH);

   logic [DATA_W-1:0] entry_q [TBL_DEPTH];
   logic              in_range;

   assign in_range = (tbl_addr < DEPTH_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_addr <= '0;
         err      <= 1'b0;
      end else begin
         if (data_wr && !in_range) err <= 1'b1;
         if (addr_wr)      tbl_addr <= addr_val;
         else if (data_wr) tbl_addr <= tbl_addr + 1'b1;
      end
   end

   for (genvar e = 0; e < int'(TBL_DEPTH); e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry_q[e] <= '0;
         else if (data_wr && in_range && (tbl_addr[IDX_W-1:0] == IDX_W'(e)))
            entry_q[e] <= data_val;
      end
   end

   always_comb begin
      rd_data = '0;
      if (32'(rd_idx) < TBL_DEPTH) rd_data = entry_q[rd_idx];
   end
endmodule

// File: rtl/irw_regspace_chan.sv
module irw_regspace_chan #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFS_W  = 16,
   localparam int unsigned FLG_W = DATA_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr,
   input  logic [DATA_W-1:0] addr_val,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_val,
   output logic [DATA_W-1:0] rs_addr,
   output logic              rq_valid,
   output logic [OFS_W-1:0]  rq_addr,
   output logic [DATA_W-1:0] rq_data
);
   logic [FLG_W-1:0] flags;
   logic [OFS_W-1:0] ofs;

   assign flags = rs_addr[DATA_W-1:OFS_W];
   assign ofs   = rs_addr[OFS_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_addr  <= '0;
         rq_valid <= 1'b0;
         rq_addr  <= '0;
         rq_data  <= '0;
      end else begin
         rq_valid <= data_wr;
         if (data_wr) begin
            rq_addr <= ofs;
            rq_data <= data_val;
         end
         if (addr_wr)      rs_addr <= addr_val;
         else if (data_wr) rs_addr <= {flags, ofs + 1'b1};
      end
   end
endmodule

// File: rtl/irw_indirect_writer.sv
module irw_indirect_writer
   import irw_pkg::*;
#(
   parameter int unsigned N_PORTS   = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned TBL_DEPTH = 12,
   localparam int unsigned IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          cr_wr_en,
   input  logic [N_PORTS*2-1:0]        cr_wr_sel,
   input  logic [N_PORTS*DATA_W-1:0]   cr_wr_data,
   input  logic [1:0]                  cr_rd_sel,
   output logic [DATA_W-1:0]           cr_rd_data,
   input  logic                        wr_flag_clr,
   output logic [3:0]                  reg_written,
   output logic                        tbl_err,
   input  logic [IDX_W-1:0]            tbl_rd_idx,
   output logic [DATA_W-1:0]           tbl_rd_data,
   output logic                        rq_valid,
   output logic [OFS_W-1:0]            rq_addr,
   output logic [DATA_W-1:0]           rq_data
);
   if (N_PORTS < 1) begin : g_bad_ports
      $error("N_PORTS must be at least 1");
   end
   if (OFS_W < 1 || OFS_W >= DATA_W) begin : g_bad_ofs
      $error("OFS_W must lie between 1 and DATA_W-1");
   end
   if (TBL_DEPTH < 2 || TBL_DEPTH > 1024) begin : g_bad_depth
      $error("TBL_DEPTH out of supported range");
   end

   logic [IRW_NREGS-1:0]             hit;
   logic [IRW_NREGS-1:0][DATA_W-1:0] hit_data;
   logic [DATA_W-1:0]                tbl_addr;
   logic [DATA_W-1:0]                rs_addr;

   irw_port_decode #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) i_decode (
      .wr_en    (cr_wr_en),
      .wr_sel   (cr_wr_sel),
      .wr_data  (cr_wr_data),
      .hit      (hit),
      .hit_data (hit_data)
   );

   irw_table_chan #(.DATA_W(DATA_W), .TBL_DEPTH(TBL_DEPTH)) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_wr  (hit[SEL_TBL_ADDR]),
      .addr_val (hit_data[SEL_TBL_ADDR]),
      .data_wr  (hit[SEL_TBL_DATA]),
      .data_val (hit_data[SEL_TBL_DATA]),
      .rd_idx   (tbl_rd_idx),
      .rd_data  (tbl_rd_data),
      .tbl_addr (tbl_addr),
      .err      (tbl_err)
   );

   irw_regspace_chan #(.DATA_W(DATA_W), .OFS_W(OFS_W)) i_regspace (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_wr  (hit[SEL_RS_ADDR]),
      .addr_val (hit_data[SEL_RS_ADDR]),
      .data_wr  (hit[SEL_RS_DATA]),
      .data_val (hit_data[SEL_RS_DATA]),
      .rs_addr  (rs_addr),
      .rq_valid (rq_valid),
      .rq_addr  (rq_addr),
      .rq_data  (rq_data)
   );

   // A write in the same cycle as a clear wins for its own bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           reg_written <= '0;
      else if (wr_flag_clr) reg_written <= hit;
      else                  reg_written <= reg_written | hit;
   end

   always_comb begin
      unique case (irw_sel_e'(cr_rd_sel))
         SEL_TBL_ADDR: cr_rd_data = tbl_addr;
         SEL_RS_ADDR:  cr_rd_data = rs_addr;
         default:      cr_rd_data = '0;
      endcase
   end
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFS_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        hit,
   input logic [DATA_W-1:0] rs_wdata,
   input logic [DATA_W-1:0] rs_addr,
   input logic [DATA_W-1:0] tbl_addr,
   input logic              tbl_err,
   input logic              rq_valid,
   input logic [OFS_W-1:0]  rq_addr
);
   AST_RQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> $past(hit[3])); // R3
   AST_RQ_OLD_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> rq_addr == $past(rs_addr[OFS_W-1:0])); // R3
   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[3] && !hit[2]) |=> rs_addr[DATA_W-1:OFS_W] == $past(rs_addr[DATA_W-1:OFS_W])); // R4
   AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[3] && !hit[2]) |=> rs_addr[OFS_W-1:0] == OFS_W'($past(rs_addr[OFS_W-1:0]) + 1'b1)); // R5
   AST_ADDR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      hit[2] |=> rs_addr == $past(rs_wdata)); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_err |=> tbl_err); // R6
   AST_TBL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[1] && !hit[0]) |=> tbl_addr == $past(tbl_addr) + 1'b1); // R2
endmodule

bind irw_indirect_writer irw_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) i_irw_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit      (hit),
   .rs_wdata (hit_data[2]),
   .rs_addr  (rs_addr),
   .tbl_addr (tbl_addr),
   .tbl_err  (tbl_err),
   .rq_valid (rq_valid),
   .rq_addr  (rq_addr)
);

// File: tb/test_irw_indirect_writer.sv
`timescale 1ns/1ps
module test_irw_indirect_writer;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    en = '0;
   logic [3:0]    sel = '0;
   logic [63:0]   wd = '0;
   logic [1:0]    rsel = '0;
   logic [DW-1:0] rdata;
   logic          clr = 1'b0;
   logic [3:0]    written;
   logic          err;
   logic [3:0]    ridx = '0;
   logic [DW-1:0] tdata;
   logic          rqv;
   logic [15:0]   rqa;
   logic [DW-1:0] rqd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irw_indirect_writer i_irw_indirect_writer (
      .clk(clk), .rst_n(rst_n), .cr_wr_en(en), .cr_wr_sel(sel), .cr_wr_data(wd),
      .cr_rd_sel(rsel), .cr_rd_data(rdata), .wr_flag_clr(clr), .reg_written(written),
      .tbl_err(err), .tbl_rd_idx(ridx), .tbl_rd_data(tdata),
      .rq_valid(rqv), .rq_addr(rqa), .rq_data(rqd)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input int p, input logic [1:0] s, input logic [DW-1:0] d);
      en[p] = 1'b1;
      sel[p*2 +: 2] = s;
      wd[p*DW +: DW] = d;
   endtask

   // Called at a falling edge: the staged writes take the next rising edge.
   task automatic go();
      @(negedge clk);
      en = '0;
      clr = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
      put(0, s, d);
      go();
   endtask

   task automatic rd(input logic [1:0] s, output logic [DW-1:0] v);
      rsel = s;
      #1 v = rdata;
   endtask

   task automatic tbl(input logic [3:0] i, output logic [DW-1:0] v);
      ridx = i;
      #1 v = tdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      rd(2'd0, v); chk(v == 0, "R1 table addr", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 reg addr", v, 0);
      chk(rqv == 0, "R1 rq_valid", DW'(rqv), 0);
      chk(err == 0, "R1 tbl_err", DW'(err), 0);
      chk(written == 0, "R1 reg_written", DW'(written), 0);
   endtask

   task automatic t_table();
      logic [DW-1:0] v;
      wr(2'd0, 32'd3);
      wr(2'd1, 32'hCAFE0001);
      wr(2'd1, 32'hCAFE0002);
      tbl(4'd3, v); chk(v == 32'hCAFE0001, "R2 entry 3", v, 32'hCAFE0001);
      tbl(4'd4, v); chk(v == 32'hCAFE0002, "R2 entry 4", v, 32'hCAFE0002);
      rd(2'd0, v); chk(v == 32'd5, "R2 R8 table addr readback", v, 5);
      rd(2'd1, v); chk(v == 0, "R8 data select reads zero", v, 0);
   endtask

   task automatic t_regspace();
      logic [DW-1:0] v;
      wr(2'd2, 32'hABCD0010);
      wr(2'd3, 32'h12345678);
      chk(rqv == 1'b1, "R3 rq_valid pulse", DW'(rqv), 1);
      chk(rqa == 16'h0010, "R3 rq_addr", DW'(rqa), 32'h10);
      chk(rqd == 32'h12345678, "R3 rq_data", rqd, 32'h12345678);
      @(negedge clk);
      chk(rqv == 1'b0, "R3 pulse one cycle", DW'(rqv), 0);
      rd(2'd2, v); chk(v == 32'hABCD0011, "R4 flags kept", v, 32'hABCD0011);
   endtask

   task automatic t_wrap();
      logic [DW-1:0] v;
      wr(2'd2, 32'h5A5AFFFF);
      wr(2'd3, 32'h0BADF00D);
      chk(rqa == 16'hFFFF, "R5 last offset", DW'(rqa), 32'hFFFF);
      rd(2'd2, v); chk(v == 32'h5A5A0000, "R5 wrap no carry", v, 32'h5A5A0000);
   endtask

   task automatic t_range();
      logic [DW-1:0] v;
      wr(2'd0, 32'd11);
      wr(2'd1, 32'h0000C0DE);
      tbl(4'd11, v); chk(v == 32'h0000C0DE, "R6 last entry", v, 32'hC0DE);
      chk(err == 1'b0, "R6 no error in range", DW'(err), 0);
      wr(2'd1, 32'hDEAD0000);
      chk(err == 1'b1, "R6 error set", DW'(err), 1);
      tbl(4'd11, v); chk(v == 32'h0000C0DE, "R6 dropped write", v, 32'hC0DE);
      rd(2'd0, v); chk(v == 32'd13, "R6 address advanced", v, 13);
      wr(2'd0, 32'd0);
      chk(err == 1'b1, "R6 error sticky", DW'(err), 1);
   endtask

   task automatic t_collide();
      logic [DW-1:0] v;
      wr(2'd2, 32'h11110020);
      put(0, 2'd3, 32'h77777777);
      put(1, 2'd2, 32'h00770040);
      go();
      chk(rqv == 1'b1 && rqa == 16'h0020, "R7 data uses old offset", DW'(rqa), 32'h20);
      rd(2'd2, v); chk(v == 32'h00770040, "R7 direct addr wins", v, 32'h00770040);
      wr(2'd0, 32'd2);
      put(0, 2'd1, 32'h5EED5EED);
      put(1, 2'd0, 32'd7);
      go();
      tbl(4'd2, v); chk(v == 32'h5EED5EED, "R7 table data at old addr", v, 32'h5EED5EED);
      rd(2'd0, v); chk(v == 32'd7, "R7 table direct addr wins", v, 7);
   endtask

   task automatic t_ports();
      logic [DW-1:0] v;
      put(0, 2'd0, 32'd4);
      put(1, 2'd0, 32'd9);
      go();
      rd(2'd0, v); chk(v == 32'd9, "R10 higher port wins", v, 9);
   endtask

   task automatic t_written();
      clr = 1'b1;
      go();
      chk(written == 4'b0000, "R9 clear", DW'(written), 0);
      wr(2'd2, 32'h0);
      chk(written == 4'b0100, "R9 bit set", DW'(written), 32'h4);
      clr = 1'b1;
      put(0, 2'd0, 32'd1);
      go();
      chk(written == 4'b0001, "R9 write beats clear", DW'(written), 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_table();
      t_regspace();
      t_wrap();
      t_range();
      t_collide();
      t_ports();
      t_written();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule